// File: doc/BRIEF.md
# Interrupt Route Byte Decoder

This block keeps the routing table of an interrupt controller: for every interrupt line it stores the number of the core that should receive it. Software programs the table with 32-bit route words. Each word carries four 8-bit route fields, and those fields set the routes of four neighbouring lines in a single write.

Every route field is decoded before it is stored. The decode mode comes from a flag input that a separate configuration register drives. With the flag low, a field is a one-hot core mask. The stored core is the position of its lowest set bit, and anything that cannot name one of the four legacy cores falls back to core 0. With the flag high, the field is a binary core number and is stored as it is, so up to 256 cores can be addressed.

An entry whose decoded value already matches the stored value is not rewritten. Every entry that does change raises its own strobe bit for one cycle, so downstream per-core state can be refreshed only where it is needed.

Top module: `irq_route_decoder`

## Requirements
- R1: A write with base B = wr_index with bits [1:0] cleared updates entries B..B+3, where bits [8l+7:8l] of wr_data feed entry B+l for lane l = 0..3.
- R2: When cpu_code_mode is 0, a field is decoded to the bit position of its lowest set bit if that position is 0, 1, 2 or 3.
- R3: When cpu_code_mode is 0 and the lowest set bit of a field is at position 4 or higher, the entry is written with core 0.
- R4: When cpu_code_mode is 1, the 8-bit field is stored unchanged as the core number.
- R5: When cpu_code_mode is 0, a field of 0x00 decodes to core 0.
- R6: An entry whose decoded value equals its stored value keeps its value, and its strobe bit stays 0.
- R7: In the cycle after a write edge, chg_mask bit l is 1 exactly when entry B+l changed value, and chg_base shows B. In every cycle that does not follow a write, chg_mask is 0.
- R8: While rst_n is low, all 256 entries are cleared to 0 and chg_mask and chg_base are cleared to 0.
- R9: Bits [1:0] of wr_index are ignored, so the write always lands on the aligned group of four entries.
- R10: rd_route shows the entry selected by rd_index with no clock delay, and it shows a written value from the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Route word write strobe |
| wr_index | input | 8 | First line of the group; bits [1:0] are ignored |
| wr_data | input | 32 | Four route fields; lane l is in bits [8l+7:8l] |
| cpu_code_mode | input | 1 | 0 selects one-hot decode with fallback to core 0, 1 selects a binary core number |
| rd_index | input | 8 | Entry selected for reading |
| rd_route | output | 8 | Stored core number of the selected entry |
| chg_mask | output | 4 | One bit per lane, set for one cycle when that entry changed |
| chg_base | output | 8 | Aligned base index of the last write |

## Verification
The bench builds the block with its default parameters: 256 lines of 8 bits, four lanes per word and four legacy cores. These values let it reach the last aligned group at index 252, use full 8-bit binary core numbers above 127, and try one-hot fields whose lowest set bit lies above the legacy range. Vectors that repeat stored values in the other mode check that strobes follow the decoded value and not the raw field. An unaligned index and a reset in the middle of the run cover alignment and clearing of the whole table.

// File: rtl/irbd_pkg.sv
package irbd_pkg;

    // Interpretation of one route field, chosen by the configuration flag.
    typedef enum logic {
        DEC_ONEHOT = 1'b0,
        DEC_BINARY = 1'b1
    } route_dec_e;

    function automatic route_dec_e mode_of(input logic flag);
        return flag ? DEC_BINARY : DEC_ONEHOT;
    endfunction

endpackage

// File: rtl/route_lane_decode.sv
module route_lane_decode
    import irbd_pkg::*;
#(
    parameter int ROUTE_W      = 8,
    parameter int LEGACY_CORES = 4
) (
    input  logic               binary_mode,
    input  logic [ROUTE_W-1:0] field,
    output logic [ROUTE_W-1:0] core
);

    localparam int SCAN_W = (LEGACY_CORES < ROUTE_W) ? LEGACY_CORES : ROUTE_W;

    logic [ROUTE_W-1:0] onehot_core;

    // Lowest set bit among the legacy positions. If none of them is set,
    // the lowest set bit is higher up or missing, so the result is core 0.
    always_comb begin
        onehot_core = '0;
        for (int b = SCAN_W - 1; b >= 0; b--) begin
            if (field[b]) begin
                onehot_core = ROUTE_W'(b);
            end
        end
    end

    always_comb begin
        unique case (mode_of(binary_mode))
            DEC_BINARY: core = field;
            default:    core = onehot_core;
        endcase
    end

endmodule

// File: rtl/route_table_bank.sv
module route_table_bank #(
    parameter int NUM_LINES = 256,
    parameter int ROUTE_W   = 8,
    parameter int LANES     = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(NUM_LINES)-1:0]    wr_index,
    input  logic [LANES-1:0][ROUTE_W-1:0]   lane_core,
    input  logic [$clog2(NUM_LINES)-1:0]    rd_index,
    output logic [ROUTE_W-1:0]              rd_route,
    output logic [LANES-1:0]                chg_mask,
    output logic [$clog2(NUM_LINES)-1:0]    chg_base
);

    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic [NUM_LINES-1:0][ROUTE_W-1:0] mem;
        logic [LANES-1:0]                  chg;
        logic [IDX_W-1:0]                  base;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [IDX_W-1:0] base_aligned;
    logic [LANES-1:0][IDX_W-1:0] lane_idx;

    assign base_aligned = {wr_index[IDX_W-1:LANE_W], LANE_W'(0)};

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_idx
            assign lane_idx[gl] = base_aligned | IDX_W'(gl);
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.chg = '0;
        if (wr_en) begin
            st_d.base = base_aligned;
            for (int l = 0; l < LANES; l++) begin
                if (st_q.mem[lane_idx[l]] != lane_core[l]) begin
                    st_d.mem[lane_idx[l]] = lane_core[l];
                    st_d.chg[l]           = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_route = st_q.mem[rd_index];
    assign chg_mask = st_q.chg;
    assign chg_base = st_q.base;

    // R7: a strobe bit only ever follows a write edge
    p_strobe_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_mask != '0) |-> $past(wr_en));

    // R9: the reported base is always aligned to a lane group
    p_base_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_base[LANE_W-1:0] == '0));

    generate
        for (gl = 0; gl < LANES; gl++) begin : g_chk
            // R6: an equal decoded value raises no strobe
            p_equal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (st_q.mem[lane_idx[gl]] == lane_core[gl])) |=> !chg_mask[gl]);
            // R7: a differing value always raises its strobe
            p_diff_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (st_q.mem[lane_idx[gl]] != lane_core[gl])) |=> chg_mask[gl]);
        end
    endgenerate

endmodule

// File: rtl/irq_route_decoder.sv
module irq_route_decoder #(
    parameter int NUM_LINES    = 256,
    parameter int ROUTE_W      = 8,
    parameter int LANES        = 4,
    parameter int LEGACY_CORES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_LINES)-1:0]        wr_index,
    input  logic [LANES*ROUTE_W-1:0]            wr_data,
    input  logic                                cpu_code_mode,
    input  logic [$clog2(NUM_LINES)-1:0]        rd_index,
    output logic [ROUTE_W-1:0]                  rd_route,
    output logic [LANES-1:0]                    chg_mask,
    output logic [$clog2(NUM_LINES)-1:0]        chg_base
);

    logic [LANES-1:0][ROUTE_W-1:0] lane_core;

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            route_lane_decode #(
                .ROUTE_W      (ROUTE_W),
                .LEGACY_CORES (LEGACY_CORES)
            ) dec_i (
                .binary_mode (cpu_code_mode),
                .field       (wr_data[gl*ROUTE_W +: ROUTE_W]),
                .core        (lane_core[gl])
            );

            // R3: one-hot decode never names a core beyond the legacy set
            p_legacy_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !cpu_code_mode) |-> (lane_core[gl] < ROUTE_W'(LEGACY_CORES)));
            // R4: binary decode passes the field through
            p_binary_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && cpu_code_mode) |-> (lane_core[gl] == wr_data[gl*ROUTE_W +: ROUTE_W]));
            // R5: an empty one-hot field falls back to core 0
            p_empty_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !cpu_code_mode && (wr_data[gl*ROUTE_W +: ROUTE_W] == '0))
                |-> (lane_core[gl] == '0));
        end
    endgenerate

    route_table_bank #(
        .NUM_LINES (NUM_LINES),
        .ROUTE_W   (ROUTE_W),
        .LANES     (LANES)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_index  (wr_index),
        .lane_core (lane_core),
        .rd_index  (rd_index),
        .rd_route  (rd_route),
        .chg_mask  (chg_mask),
        .chg_base  (chg_base)
    );

endmodule

// File: tb/irq_route_decoder_tb_top.sv
module irq_route_decoder_tb_top;

    localparam int LINES = 256;
    localparam int NV    = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_index;
    logic [31:0] wr_data;
    logic        cpu_code_mode;
    logic [7:0]  rd_index;
    logic [7:0]  rd_route;
    logic [3:0]  chg_mask;
    logic [7:0]  chg_base;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic [7:0] mdl [LINES];

    always #5 clk = ~clk;

    irq_route_decoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_index      (wr_index),
        .wr_data       (wr_data),
        .cpu_code_mode (cpu_code_mode),
        .rd_index      (rd_index),
        .rd_route      (rd_route),
        .chg_mask      (chg_mask),
        .chg_base      (chg_base)
    );

    // {mode, index, data}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 8'd0,   32'h0804_0201},  // R2 each legacy position
        {1'b0, 8'd4,   32'h0030_1080},  // R3 high bits, R5 zero field
        {1'b0, 8'd8,   32'h0C06_FF0A},  // R2 lowest of several bits
        {1'b1, 8'd12,  32'hFF80_0107},  // R4 binary values
        {1'b1, 8'd0,   32'h0302_0100},  // R6 equal values in binary mode
        {1'b0, 8'd13,  32'h0101_0101},  // R9 unaligned index
        {1'b1, 8'd255, 32'hAB00_CD11},  // R1 top group, R9
        {1'b0, 8'd0,   32'h0000_0008}   // R2 bit 3, R5
    };

    function automatic logic [7:0] ref_dec(input logic m, input logic [7:0] f);
        if (m) return f;
        for (int i = 0; i < 4; i++) begin
            if (f[i]) return 8'(i);
        end
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic m, input logic [7:0] idx, input logic [31:0] d);
        logic [7:0] base;
        logic [3:0] emask;
        base  = {idx[7:2], 2'b00};
        emask = '0;
        for (int l = 0; l < 4; l++) begin
            logic [7:0] nv;
            nv = ref_dec(m, d[8*l +: 8]);
            if (nv != mdl[base + 8'(l)]) begin
                emask[l] = 1'b1;
                mdl[base + 8'(l)] = nv;
            end
        end
        @(negedge clk);
        wr_en         = 1'b1;
        wr_index      = idx;
        wr_data       = d;
        cpu_code_mode = m;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        chk("R7 R6 chg_mask", 32'(chg_mask), 32'(emask));
        chk("R7 R9 chg_base", 32'(chg_base), 32'(base));
        for (int l = 0; l < 4; l++) begin
            rd_index = base + 8'(l);
            #1;
            chk("R1 R2 R3 R4 R5 R10 route", 32'(rd_route), 32'(mdl[base + 8'(l)]));
        end
        @(posedge clk);
        #1;
        chk("R7 strobe one cycle", 32'(chg_mask), 32'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_index = '0; wr_data = '0;
        cpu_code_mode = 1'b0; rd_index = '0;
        for (int i = 0; i < LINES; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk("R8 chg_mask reset", 32'(chg_mask), 32'h0);
        chk("R8 chg_base reset", 32'(chg_base), 32'h0);
        rd_index = 8'd0;   #1; chk("R8 entry 0", 32'(rd_route), 32'h0);
        rd_index = 8'd255; #1; chk("R8 entry 255", 32'(rd_route), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][40], VEC[v][39:32], VEC[v][31:0]);
        end

        // R6: the same word again changes nothing, values hold
        do_write(1'b1, 8'd252, 32'hAB00_CD11);
        // R6: legacy field equal to stored core after decode
        do_write(1'b0, 8'd8, 32'h0402_FF02);
        // R9: index with low bits 2'b10 lands on base 16
        do_write(1'b1, 8'd18, 32'h0405_0607);

        // R8: reset in the middle of a run clears the table
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < LINES; i++) mdl[i] = 8'h00;
        rd_index = 8'd12;  #1; chk("R8 entry 12 cleared", 32'(rd_route), 32'h0);
        rd_index = 8'd252; #1; chk("R8 entry 252 cleared", 32'(rd_route), 32'h0);
        rd_index = 8'd17;  #1; chk("R8 entry 17 cleared", 32'(rd_route), 32'h0);
        chk("R8 chg_base cleared", 32'(chg_base), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        do_write(1'b0, 8'd12, 32'h2040_8001);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule